// File: doc/BRIEF.md
# GPIO Interrupt Controller

This block gives software control of 24 general-purpose pins through a 16-bit register bus. Each pin can be an output, driven from a data latch, or an input, whose level software can read. Any input can also raise an interrupt on a high level, a low level, a rising edge, a falling edge or on both edges. Interrupt events are held in per-port status bits. A per-port enable mask gates those bits, and the gated bits are combined into one active-high interrupt line.

Every 24-bit quantity is split over two bus words. The even word address carries ports 0 to 15. The next odd address carries ports 16 to 23 in bits 7:0. The trigger polarity and both-edge selection for each group of eight ports share one 16-bit option word. Pin inputs pass through a two-flop synchroniser before any use. Detection is held off for a few cycles after reset, until the synchroniser holds real pin values.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the direction, enable, trigger-type, option, data-latch and status registers all read 0. `pin_oe`, `pin_out` and `irq` are 0. While inputs sit high, no status bit sets after reset.
- R2: Word addresses are: data 0/1, direction 2/3, enable 4/5, trigger type 6/7, status 8/9, option words 10, 11 and 12 for ports 0–7, 8–15 and 16–23. In every odd (upper) word, bits 15:8 read 0 and ignore writes. Unmapped addresses read 0.
- R3: A write to the data words drives `pin_out` at the next clock edge. A read of the data words returns `pin_in` as it was two clock edges earlier. `pin_out` changes only after a data write.
- R4: `pin_oe` equals the direction register, where 1 means output. A port whose direction bit is 1 never sets its status bit.
- R5: For a level-typed port (type bit 0), the option low-byte bit 1 selects active high and 0 selects active low. The status bit sets on every cycle the active level is present, so a clear does not hold while that level remains.
- R6: For an edge-typed port (type bit 1) whose both-edges bit is 0, option low-byte bit 1 selects rising and 0 selects falling. Only the chosen transition sets status.
- R7: For an edge-typed port whose option high-byte bit is 1, both transitions set status, whatever the low-byte bit holds.
- R8: A status bit stays set until a 1 is written to its position in the status word. Writing 0 leaves it unchanged.
- R9: `irq` is the registered OR of status AND enable. It rises one clock after the enable or status is set, and it falls one clock after the enable or status is removed. A disabled status bit is still latched and readable.
- R10: Port p takes its polarity from bit (p mod 8), and its both-edges select from bit (p mod 8)+8, of option word p/8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Bus access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from address |
| pin_in | input | 24 | Pin levels (asynchronous) |
| pin_out | output | 24 | Output data latch |
| pin_oe | output | 24 | Output enable per pin |
| irq | output | 1 | Combined interrupt, active high |

## Verification
A wrong status bit shows up in the next status-word read. If its enable is set, it also shows on `irq` within one clock. The bench therefore reads status after every stimulus and times `irq` to the exact cycle around each enable and clear write. A corrupted trigger decode, or a swapped bit in an option word, changes whether a given transition sets status. This is visible three clocks after the pin moves, once the synchroniser and edge register have passed it on. The bench waits past that point and reads the status word. Faults in the synchroniser or in data-latch decode show directly on `pin_out` or in the data-word read.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   // register pair indices (word address >> 1)
   localparam int PAIR_DATA = 0;
   localparam int PAIR_DIR  = 1;
   localparam int PAIR_EN   = 2;
   localparam int PAIR_TYP  = 3;
   localparam int PAIR_STAT = 4;
   localparam int NUM_PAIRS = 5;
   // first option word address, one word per group of ports
   localparam int OPT_BASE  = 10;
   localparam int GRP_PORTS = 8;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 24,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_pkg::*;
#(
   parameter int NUM_PORTS = 24,
   parameter int BUS_W     = 16,
   parameter int ADDR_W    = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_en,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [BUS_W-1:0]     bus_wdata,
   output logic [BUS_W-1:0]     bus_rdata,
   input  logic [NUM_PORTS-1:0] pin_lvl,
   input  logic [NUM_PORTS-1:0] stat,
   output logic [NUM_PORTS-1:0] out_q,
   output logic [NUM_PORTS-1:0] dir_q,
   output logic [NUM_PORTS-1:0] en_q,
   output logic [NUM_PORTS-1:0] typ_q,
   output logic [NUM_PORTS-1:0] pol_o,
   output logic [NUM_PORTS-1:0] both_o,
   output logic [NUM_PORTS-1:0] clr
);
   localparam int HI_W  = NUM_PORTS - BUS_W;
   localparam int NGRP  = (NUM_PORTS + GRP_PORTS - 1) / GRP_PORTS;
   localparam int OPT_W = 2 * GRP_PORTS;

   logic [OPT_W-1:0] opt_q [NGRP];
   logic             wr;
   logic             hi;
   int               pair;
   int               adr;

   assign wr   = bus_en & bus_wr;
   assign hi   = bus_addr[0];
   assign pair = int'(bus_addr[ADDR_W-1:1]);
   assign adr  = int'(bus_addr);

   function automatic logic [NUM_PORTS-1:0] merge_word(
      input logic [NUM_PORTS-1:0] old,
      input logic                 upper,
      input logic [BUS_W-1:0]     d);
      logic [NUM_PORTS-1:0] r;
      r = old;
      if (upper) r[NUM_PORTS-1:BUS_W] = d[HI_W-1:0];
      else       r[BUS_W-1:0]         = d;
      return r;
   endfunction

   function automatic logic [BUS_W-1:0] pick_word(
      input logic [NUM_PORTS-1:0] v,
      input logic                 upper);
      if (upper) return BUS_W'(v[NUM_PORTS-1:BUS_W]);
      return v[BUS_W-1:0];
   endfunction

   // plain read/write registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         dir_q <= '0;
         en_q  <= '0;
         typ_q <= '0;
      end else if (wr) begin
         if (pair == PAIR_DATA) out_q <= merge_word(out_q, hi, bus_wdata);
         if (pair == PAIR_DIR)  dir_q <= merge_word(dir_q, hi, bus_wdata);
         if (pair == PAIR_EN)   en_q  <= merge_word(en_q,  hi, bus_wdata);
         if (pair == PAIR_TYP)  typ_q <= merge_word(typ_q, hi, bus_wdata);
      end
   end

   // trigger option words, one per group of ports
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int g = 0; g < NGRP; g++) opt_q[g] <= '0;
      end else begin
         for (int g = 0; g < NGRP; g++)
            if (wr && adr == OPT_BASE + g) opt_q[g] <= bus_wdata[OPT_W-1:0];
      end
   end

   // write-one-to-clear pulse toward the status register
   always_comb begin
      clr = '0;
      if (wr && pair == PAIR_STAT) clr = merge_word('0, hi, bus_wdata);
   end

   // per-port fan-out of the shared option words
   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_opt
         assign pol_o[p]  = opt_q[p / GRP_PORTS][p % GRP_PORTS];
         assign both_o[p] = opt_q[p / GRP_PORTS][(p % GRP_PORTS) + GRP_PORTS];
      end
   endgenerate

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (pair == PAIR_DATA)      bus_rdata = pick_word(pin_lvl, hi);
      else if (pair == PAIR_DIR)  bus_rdata = pick_word(dir_q, hi);
      else if (pair == PAIR_EN)   bus_rdata = pick_word(en_q, hi);
      else if (pair == PAIR_TYP)  bus_rdata = pick_word(typ_q, hi);
      else if (pair == PAIR_STAT) bus_rdata = pick_word(stat, hi);
      else begin
         for (int g = 0; g < NGRP; g++)
            if (adr == OPT_BASE + g) bus_rdata = BUS_W'(opt_q[g]);
      end
   end
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
   parameter int NUM_PORTS = 24,
   parameter int WARM      = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PORTS-1:0] lvl,
   input  logic [NUM_PORTS-1:0] dir,
   input  logic [NUM_PORTS-1:0] typ,
   input  logic [NUM_PORTS-1:0] pol,
   input  logic [NUM_PORTS-1:0] both,
   output logic [NUM_PORTS-1:0] set
);
   logic [NUM_PORTS-1:0] prev_q;
   logic [WARM-1:0]      warm_q;
   logic                 live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         warm_q <= '0;
      end else begin
         prev_q <= lvl;
         warm_q <= {warm_q[WARM-2:0], 1'b1};
      end
   end

   assign live = warm_q[WARM-1];

   generate
      if (WARM < 2) begin : g_bad_warm
         $error("gpio_trig_detect warm-up must span at least two cycles");
      end
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         logic rise, fall, edge_hit, lvl_hit;
         assign rise     = lvl[p] & ~prev_q[p];
         assign fall     = ~lvl[p] & prev_q[p];
         assign edge_hit = both[p] ? (rise | fall) : (pol[p] ? rise : fall);
         assign lvl_hit  = pol[p] ? lvl[p] : ~lvl[p];
         assign set[p]   = live & ~dir[p] & (typ[p] ? edge_hit : lvl_hit);
      end
   endgenerate
endmodule

// File: rtl/gpio_status.sv
module gpio_status #(
   parameter int NUM_PORTS = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PORTS-1:0] set,
   input  logic [NUM_PORTS-1:0] clr,
   input  logic [NUM_PORTS-1:0] en,
   output logic [NUM_PORTS-1:0] stat_q,
   output logic                 irq_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         // a new event in the same cycle as its clear wins
         stat_q <= (stat_q & ~clr) | set;
         irq_q  <= |(stat_q & en);
      end
   end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_pkg::*;
#(
   parameter int NUM_PORTS   = 24,
   parameter int BUS_W       = 16,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_en,
   input  logic                 reg_wr,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [BUS_W-1:0]     reg_wdata,
   output logic [BUS_W-1:0]     reg_rdata,
   input  logic [NUM_PORTS-1:0] pin_in,
   output logic [NUM_PORTS-1:0] pin_out,
   output logic [NUM_PORTS-1:0] pin_oe,
   output logic                 irq
);
   localparam int NGRP = (NUM_PORTS + GRP_PORTS - 1) / GRP_PORTS;
   localparam int WARM = SYNC_STAGES + 1;

   generate
      if (NUM_PORTS <= BUS_W || NUM_PORTS > 2 * BUS_W) begin : g_bad_ports
         $error("NUM_PORTS must need exactly two bus words");
      end
      if (BUS_W < 2 * GRP_PORTS) begin : g_bad_bus
         $error("bus too narrow for an option word");
      end
      if (OPT_BASE + NGRP > (1 << ADDR_W) || 2 * NUM_PAIRS > OPT_BASE) begin : g_bad_addr
         $error("address map does not fit");
      end
   endgenerate

   logic [NUM_PORTS-1:0] lvl_s;
   logic [NUM_PORTS-1:0] out_q, dir_q, en_q, typ_q, pol_v, both_v, clr_v;
   logic [NUM_PORTS-1:0] set_v, stat_q;
   logic                 irq_q;

   gpio_sync #(.W(NUM_PORTS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl_s));

   gpio_regfile #(.NUM_PORTS(NUM_PORTS), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_en(reg_en), .bus_wr(reg_wr), .bus_addr(reg_addr),
      .bus_wdata(reg_wdata), .bus_rdata(reg_rdata),
      .pin_lvl(lvl_s), .stat(stat_q),
      .out_q(out_q), .dir_q(dir_q), .en_q(en_q), .typ_q(typ_q),
      .pol_o(pol_v), .both_o(both_v), .clr(clr_v));

   gpio_trig_detect #(.NUM_PORTS(NUM_PORTS), .WARM(WARM)) u_det (
      .clk(clk), .rst_n(rst_n), .lvl(lvl_s), .dir(dir_q), .typ(typ_q),
      .pol(pol_v), .both(both_v), .set(set_v));

   gpio_status #(.NUM_PORTS(NUM_PORTS)) u_stat (
      .clk(clk), .rst_n(rst_n), .set(set_v), .clr(clr_v), .en(en_q),
      .stat_q(stat_q), .irq_q(irq_q));

   assign pin_out = out_q;
   assign pin_oe  = dir_q;
   assign irq     = irq_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
   import gpio_pkg::*;
#(
   parameter int NUM_PORTS = 24,
   parameter int BUS_W     = 16,
   parameter int ADDR_W    = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 reg_en,
   input logic                 reg_wr,
   input logic [ADDR_W-1:0]    reg_addr,
   input logic [BUS_W-1:0]     reg_rdata,
   input logic [NUM_PORTS-1:0] pin_out,
   input logic                 irq,
   input logic [NUM_PORTS-1:0] stat,
   input logic [NUM_PORTS-1:0] en,
   input logic [NUM_PORTS-1:0] dir,
   input logic [NUM_PORTS-1:0] clr
);
   localparam int HI_W = NUM_PORTS - BUS_W;

   logic data_wr, rd_hi;
   assign data_wr = reg_en & reg_wr & (int'(reg_addr[ADDR_W-1:1]) == PAIR_DATA);
   assign rd_hi   = reg_en & ~reg_wr & reg_addr[0] & (int'(reg_addr) < 2 * NUM_PAIRS);

   // R2: upper word padding reads zero
   assert_hi_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hi |-> (reg_rdata[BUS_W-1:HI_W] == '0));

   // R3: output latch moves only after a data write
   assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(data_wr) |-> $stable(pin_out));

   // R4: output ports never gain status
   assert_no_output_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat & ~$past(stat) & $past(dir)) == '0));

   // R8: status only drops where a clear was written
   assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((~stat & $past(stat) & ~$past(clr)) == '0));

   // R9: all-zero mask silences the interrupt on the next edge
   assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |=> !irq);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
   .NUM_PORTS(NUM_PORTS), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
   .reg_addr(reg_addr), .reg_rdata(reg_rdata), .pin_out(pin_out),
   .irq(irq), .stat(stat_q), .en(en_q), .dir(dir_q), .clr(clr_v));

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_en = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [23:0] pins = 24'hFFFFFF;
   logic [23:0] pin_out, pin_oe;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [23:0] typ_sh = '0;
   logic [15:0] opt_sh [3] = '{16'h0, 16'h0, 16'h0};

   always #2 clk = ~clk;

   gpio_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pin_in(pins), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

   // {port[4:0], edge, pol, both, v0, v1, expected}
   localparam logic [10:0] VEC [13] = '{
      {5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
      {5'd1,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
      {5'd2,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
      {5'd3,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
      {5'd4,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
      {5'd5,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
      {5'd9,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
      {5'd10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
      {5'd17, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
      {5'd18, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
      {5'd23, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
      {5'd15, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
      {5'd16, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      reg_en = 1'b1; reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
      @(negedge clk);
      reg_en = 1'b0; reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [15:0] d);
      @(negedge clk);
      reg_en = 1'b1; reg_wr = 1'b0; reg_addr = 4'(a);
      #1 d = reg_rdata;
      reg_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clr_port(input int p);
      if (p < 16) begin wr(8, 16'(1 << p)); wr(8, 16'h0); end
      else        begin wr(9, 16'(1 << (p - 16))); wr(9, 16'h0); end
   endtask

   task automatic cfg_port(input int p, input logic e, input logic pol, input logic both);
      typ_sh[p] = e;
      opt_sh[p / 8][p % 8]     = pol;
      opt_sh[p / 8][p % 8 + 8] = both;
      wr(6, typ_sh[15:0]);
      wr(7, {8'h00, typ_sh[23:16]});
      wr(10 + p / 8, opt_sh[p / 8]);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      logic [15:0] s;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1 irq", 32'(irq), 0);
      chk("R1 pin_oe", 32'(pin_oe), 0);
      chk("R1 pin_out", 32'(pin_out), 0);
      idle(6);
      for (int a = 2; a < 13; a++) begin
         rd(a, d);
         chk($sformatf("R1 reg %0d", a), 32'(d), 0);
      end

      // table: trigger modes R5 R6 R7, option mapping R10
      for (int i = 0; i < 13; i++) begin
         automatic int   p   = int'(VEC[i][10:6]);
         automatic logic e   = VEC[i][5];
         automatic logic pol = VEC[i][4];
         automatic logic bth = VEC[i][3];
         automatic string req = e ? (bth ? "R7" : "R6") : "R5";
         pins[p] = VEC[i][2];
         cfg_port(p, e, pol, bth);
         idle(5);
         clr_port(p);
         pins[p] = VEC[i][1];
         idle(6);
         if (p < 16) begin rd(8, s); d = 16'(s[p]); end
         else begin rd(9, s); d = 16'(s[p - 16]); end
         chk($sformatf("%s/R10 vector %0d port %0d", req, i, p), 32'(d), 32'(VEC[i][0]));
      end
      chk("R9 masked irq", 32'(irq), 0);

      // R5: level still present -> clear does not hold (port 0 high, pin 1)
      clr_port(0);
      idle(1);
      rd(8, s);
      chk("R5 level re-set", 32'(s[0]), 1);

      // R8: writing 0 keeps status of port 4
      wr(8, 16'h0000);
      rd(8, s);
      chk("R8 zero write", 32'(s[4]), 1);

      // R9: irq timing around enable
      wr(4, 16'h0010);
      chk("R9 one cycle lag", 32'(irq), 0);
      @(negedge clk);
      chk("R9 rise", 32'(irq), 1);
      wr(4, 16'h0000);
      chk("R9 hold one cycle", 32'(irq), 1);
      @(negedge clk);
      chk("R9 fall after disable", 32'(irq), 0);
      wr(4, 16'h0010);
      @(negedge clk);
      chk("R9 re-enable", 32'(irq), 1);
      wr(8, 16'h0010);
      @(negedge clk);
      chk("R9 fall after clear", 32'(irq), 0);
      rd(8, s);
      chk("R8 one clears", 32'(s[4]), 0);
      wr(4, 16'h0000);

      // R4: output port ignores its pin
      wr(2, 16'h0040);
      chk("R4 pin_oe", 32'(pin_oe), 32'h40);
      pins[6] = 1'b0;
      cfg_port(6, 1'b1, 1'b1, 1'b0);
      idle(5);
      clr_port(6);
      pins[6] = 1'b1;
      idle(6);
      rd(8, s);
      chk("R4 output no status", 32'(s[6]), 0);

      // R3: output latch and pin read-back
      wr(0, 16'hA5C3);
      chk("R3 pin_out lo", 32'(pin_out), 32'h0000A5C3);
      wr(1, 16'hFF12);
      chk("R3 pin_out hi", 32'(pin_out), 32'h0012A5C3);
      pins = 24'h5A3C96;
      idle(3);
      rd(0, d);
      chk("R3 data read lo", 32'(d), 32'h3C96);
      rd(1, d);
      chk("R3 data read hi", 32'(d), 32'h005A);

      // R2: upper padding and unmapped addresses
      wr(3, 16'hAB12);
      rd(3, d);
      chk("R2 dir hi pad", 32'(d), 32'h0012);
      chk("R2 pin_oe hi", 32'(pin_oe[23:16]), 32'h12);
      rd(15, d);
      chk("R2 unmapped", 32'(d), 0);
      rd(11, d);
      chk("R2 opt word 1", 32'(d), 32'(opt_sh[1]));

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule